// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage of a pipelined processor. Each cycle it takes the fetch address and returns a taken flag and the next fetch address. Two direct-mapped tables are read with the same low address bits. The first holds one 2-bit hysteresis counter per entry. The second is a tagged cache of branch destinations. A taken prediction needs both a cache hit and a counter in one of its two taken states. The next fetch address is then the cached destination. In every other case it is the fall-through address, fetch address plus 4.

Later in the pipeline, a resolved branch comes back on the update port. It carries its address, its real direction and real destination, and the prediction that was made for it at fetch. In the same cycle the block raises a mispredict flag, which the flush logic uses. At the clock edge it moves the counter one step toward the real outcome. A taken branch also writes its tag and destination into the cache.

Each counter is a four-state machine. The states are CTR_STRONG_NT (00), CTR_WEAK_NT (01), CTR_WEAK_T (10) and CTR_STRONG_T (11). A taken outcome moves it one state up: STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T stays where it is. A not-taken outcome moves it one state down: STRONG_T to WEAK_T, WEAK_T to WEAK_NT, WEAK_NT to STRONG_NT, and STRONG_NT stays where it is. Bit 1 of the state is the predicted direction.

Top module: `bp_predictor`

## Requirements
- R1: After reset, every cache entry is invalid and every counter is in CTR_WEAK_NT, so no fetch address is redirected.
- R2: The table index is address bits [IDX_W+1:2] and the tag is bits [PC_W-1:IDX_W+2]. Address bits [1:0] play no part. A hit requires a valid entry whose stored tag equals the fetch tag.
- R3: pred_taken is 1 only on a hit with counter bit 1 set, and next_pc is then the stored destination. Otherwise pred_taken is 0 and next_pc is fetch_pc + 4.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. An update moves the counter one step up when taken and one step down when not taken, and it saturates at 00 and 11.
- R5: From a strong state, a single opposite outcome leaves the predicted direction unchanged, and a second consecutive one flips it.
- R6: A taken update sets the entry valid and writes its tag and destination, replacing whatever the entry held, including an entry owned by another address with the same index. A not-taken update leaves the cache entry unchanged.
- R7: mispredict is 1 in the same cycle when upd_valid is 1 and either upd_pred_taken differs from upd_taken, or upd_taken is 1 and upd_pred_target differs from upd_target. It is 0 whenever upd_valid is 0.
- R8: An update changes lookups from the cycle after its clock edge. A lookup in the update's own cycle sees the old contents.
- R9: While upd_valid is 0, the other update inputs change neither table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Fetch is redirected to the cached destination |
| next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |
| upd_target | input | PC_W | Real destination of the resolved branch |
| upd_pred_taken | input | 1 | Direction that was predicted for it at fetch |
| upd_pred_target | input | PC_W | next_pc that was predicted for it at fetch |
| mispredict | output | 1 | Prediction was wrong, flush needed |

## Verification
Four properties are checked on every cycle. A non-redirected fetch always falls through. mispredict never rises without an update. A fresh taken fill is the destination used on the next redirected fetch of that address. Two back-to-back taken updates to one address always leave it predicted taken. Only the directed scenarios can show the rest. These cover the exact counter walk through both saturation points, hysteresis against single outliers, aliasing replacement between addresses that share an index, and the same-cycle visibility of updates. They also show that the update fields are ignored while upd_valid is low, which no per-cycle property observes.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_t;

    // One step of the hysteresis machine toward the resolved outcome.
    function automatic ctr_state_t ctr_step(input ctr_state_t cur, input logic taken);
        ctr_state_t nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_WEAK_NT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
`timescale 1ns/1ps
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] dir_vec;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        ctr_state_t st_q;
        ctr_state_t st_d;

        always_comb begin
            st_d = st_q;
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                st_d = ctr_step(st_q, wr_taken);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= CTR_WEAK_NT;
            end else begin
                st_q <= st_d;
            end
        end

        assign dir_vec[e] = st_q[1];
    end

    assign rd_taken = dir_vec[rd_idx];

endmodule

// File: rtl/bp_target_buf.sv
`timescale 1ns/1ps
module bp_target_buf #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target = tgt_q[rd_idx];

endmodule

// File: rtl/bp_predictor.sv
`timescale 1ns/1ps
module bp_predictor #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            mispredict
);
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam int TAG_LO = IDX_W + 2;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             dir_taken, btb_hit;
    logic [PC_W-1:0]  btb_target;
    logic [1:0]       unused_upd_lsb;

    assign f_idx = fetch_pc[TAG_LO-1:2];
    assign f_tag = fetch_pc[PC_W-1:TAG_LO];
    assign u_idx = upd_pc[TAG_LO-1:2];
    assign u_tag = upd_pc[PC_W-1:TAG_LO];
    assign unused_upd_lsb = upd_pc[1:0];

    bp_ctr_table #(.IDX_W(IDX_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (u_idx),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (f_idx),
        .rd_tag    (f_tag),
        .rd_hit    (btb_hit),
        .rd_target (btb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_idx    (u_idx),
        .wr_tag    (u_tag),
        .wr_target (upd_target)
    );

    always_comb begin
        pred_taken = btb_hit && dir_taken;
        next_pc    = pred_taken ? btb_target : (fetch_pc + PC_W'(4));
        mispredict = upd_valid &&
                     ((upd_pred_taken != upd_taken) ||
                      (upd_taken && (upd_pred_target != upd_target)));
    end

endmodule

// File: rtl/bp_predictor_chk.sv
`timescale 1ns/1ps
module bp_predictor_chk #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_taken,
    input logic [PC_W-1:0] next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_pred_taken,
    input logic [PC_W-1:0] upd_pred_target,
    input logic            mispredict
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (next_pc == fetch_pc + PC_W'(4)));

    assert_flag_needs_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> upd_valid);

    assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            ((fetch_pc != $past(upd_pc)) || !pred_taken || (next_pc == $past(upd_target))));

    assert_two_taken_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (upd_valid && upd_taken && $past(upd_valid) && $past(upd_taken) &&
         ($past(upd_pc) == upd_pc)) |=>
            ((fetch_pc != $past(upd_pc)) || pred_taken));

endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_bp_predictor.sv
`timescale 1ns/1ps
module test_bp_predictor;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken;
    logic [PC_W-1:0] next_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;
    logic            upd_pred_taken = 1'b0;
    logic [PC_W-1:0] upd_pred_target = '0;
    logic            mispredict;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Index bits [5:2], tag bits [31:6] with the default IDX_W of 4.
    localparam logic [31:0] PC_A  = 32'h0000_1044;  // index 1
    localparam logic [31:0] PC_B  = 32'h0000_2044;  // index 1, other tag
    localparam logic [31:0] PC_C  = 32'h0000_1048;  // index 2
    localparam logic [31:0] TGT_1 = 32'h0000_3000;
    localparam logic [31:0] TGT_2 = 32'h0000_3400;
    localparam logic [31:0] TGT_3 = 32'h0000_5000;

    always #10 clk = ~clk;

    bp_predictor i_bp_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .next_pc(next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
        .mispredict(mispredict)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc,
                        input logic exp_tk, input logic [31:0] exp_nxt);
        fetch_pc = pc;
        #2;
        check({req, " taken"}, 32'(pred_taken), 32'(exp_tk));
        check({req, " next_pc"}, next_pc, exp_nxt);
    endtask

    task automatic update(input string req, input logic [31:0] pc, input logic tk,
                          input logic [31:0] tgt, input logic ptk, input logic [31:0] ptgt,
                          input logic exp_mis);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        upd_pred_taken = ptk; upd_pred_target = ptgt;
        #2;
        check({req, " mispredict"}, 32'(mispredict), 32'(exp_mis));
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        look("R1 reset A", PC_A, 1'b0, PC_A + 4);
        look("R1 reset C", PC_C, 1'b0, PC_C + 4);
        check("R7 idle flag", 32'(mispredict), 32'd0);
    endtask

    task automatic t_first_fill;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = PC_A; upd_taken = 1'b1; upd_target = TGT_1;
        upd_pred_taken = 1'b0; upd_pred_target = PC_A + 4;
        look("R8 same-cycle old view", PC_A, 1'b0, PC_A + 4);
        check("R7 direction wrong", 32'(mispredict), 32'd1);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        look("R3 R6 filled redirect", PC_A, 1'b1, TGT_1);
        look("R2 low bits ignored", PC_A + 3, 1'b1, TGT_1);
        look("R2 other index untouched", PC_C, 1'b0, PC_C + 4);
    endtask

    task automatic t_hysteresis;
        // WEAK_T -> STRONG_T, then two not-taken outcomes.
        update("R7 correct", PC_A, 1'b1, TGT_1, 1'b1, TGT_1, 1'b0);
        update("R5 first outlier", PC_A, 1'b0, TGT_2, 1'b1, TGT_1, 1'b1);
        look("R5 R6 direction held", PC_A, 1'b1, TGT_1);
        update("R5 second outlier", PC_A, 1'b0, TGT_2, 1'b1, TGT_1, 1'b1);
        look("R5 direction flipped", PC_A, 1'b0, PC_A + 4);
    endtask

    task automatic t_saturation;
        // WEAK_NT -> STRONG_NT, stays there, then one taken is still not-taken.
        update("R4 down", PC_A, 1'b0, TGT_1, 1'b0, PC_A + 4, 1'b0);
        update("R4 floor", PC_A, 1'b0, TGT_1, 1'b0, PC_A + 4, 1'b0);
        update("R4 up one", PC_A, 1'b1, TGT_1, 1'b0, PC_A + 4, 1'b1);
        look("R4 low saturation", PC_A, 1'b0, PC_A + 4);
        update("R4 up two", PC_A, 1'b1, TGT_1, 1'b0, PC_A + 4, 1'b1);
        look("R4 weak taken", PC_A, 1'b1, TGT_1);
        update("R4 up three", PC_A, 1'b1, TGT_1, 1'b1, TGT_1, 1'b0);
        update("R4 ceiling", PC_A, 1'b1, TGT_1, 1'b1, TGT_1, 1'b0);
        update("R4 ceiling again", PC_A, 1'b1, TGT_1, 1'b1, TGT_1, 1'b0);
        update("R4 down from top", PC_A, 1'b0, TGT_1, 1'b1, TGT_1, 1'b1);
        look("R4 high saturation", PC_A, 1'b1, TGT_1);
    endtask

    task automatic t_retarget;
        update("R7 target wrong", PC_A, 1'b1, TGT_2, 1'b1, TGT_1, 1'b1);
        look("R6 new target", PC_A, 1'b1, TGT_2);
    endtask

    task automatic t_alias;
        update("R6 alias fill", PC_B, 1'b1, TGT_3, 1'b1, TGT_2, 1'b1);
        look("R2 tag mismatch", PC_A, 1'b0, PC_A + 4);
        look("R6 alias owns entry", PC_B, 1'b1, TGT_3);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        upd_valid = 1'b0; upd_pc = PC_C; upd_taken = 1'b1; upd_target = TGT_2;
        upd_pred_taken = 1'b0; upd_pred_target = TGT_1;
        #2;
        check("R7 no flag without valid", 32'(mispredict), 32'd0);
        repeat (3) @(posedge clk);
        #1;
        look("R9 C unchanged", PC_C, 1'b0, PC_C + 4);
        look("R9 B unchanged", PC_B, 1'b1, TGT_3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_first_fill();
        t_hysteresis();
        t_saturation();
        t_retarget();
        t_alias();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule